// File: doc/BRIEF.md
# Security-Gated Block Lookup Register File

This block is the configuration register file of a memory protection controller. It keeps a control word, a pointer that selects one lookup word, and an array of lookup words. Each lookup word holds one security bit for each of 32 consecutive memory blocks. A bit value of 0 marks a block as secure. A filter block elsewhere reads the selected word, the lockdown state and the error-response mode from this block. That filter also supplies the interrupt status and the captured fault address and fault attributes, which this block only reads.

Software reaches the lookup array only through an index register. The index can step forward by itself after each full-word access to the lookup-data register, and it wraps at the number of lookup words. A sticky lockdown bit freezes the control, lookup-data and interrupt-enable registers until reset. Masters without the secure attribute see only the identification region at the top of the 4 KiB window. Writes to the interrupt set and clear registers leave this block as one-cycle strobes that go to the status logic.

The register port takes a request in any cycle and never stalls. No ready signal exists, so the port applies no back-pressure. Every request gets a response exactly one cycle later. Byte, halfword and word accesses are all accepted.

Top module: `mpc_lut_regfile`

## Requirements
- R1: Reset state:
  - control reads 0x00000100 (auto-increment on);
  - index reads 0 and interrupt enable reads 1;
  - every lookup word is zero;
  - `lockdown_o`, `sec_resp_o` and `irq_o` are 0.
- R2: Control keeps only three bits:
  - bit 4 selects the error response and drives `sec_resp_o`;
  - bit 8 enables auto-increment;
  - bit 31 is lockdown and drives `lockdown_o`;
  - every other control bit reads 0 and ignores writes.
- R3: A request with `req_secure`=0 to an offset below 0xFD0:
  - reads 0 and changes no state;
  - emits no strobe;
  - still gets its response.
- R4: Reads and writes of lookup data (offset 0x1C) act on the word selected by the index. `lut_word_o` and `lut_index_o` show the selected word and the index.
- R5: With auto-increment set, a granted full-word access to lookup data advances the index after the access. The index wraps from LUT_WORDS-1 to 0. Byte and halfword accesses never advance it, and neither does any access while auto-increment is clear.
- R6: A write to the index register (offset 0x18) stores the merged written value modulo LUT_WORDS.
- R7: While lockdown is set:
  - writes to control (0x00), lookup data (0x1C) and interrupt enable (0x28) are ignored;
  - an ignored lookup write does not advance the index;
  - reads still advance it;
  - only reset clears lockdown.
- R8: Sub-word writes (`req_size` 0 = byte, 1 = halfword) place the low bytes of `req_wdata` at the byte lanes starting at `req_addr[1:0]`. For control, index and lookup data the result merges into the current value. For every other register it merges into zero.
- R9: A sub-word read returns the addressed bytes of the 32-bit register, moved down to bit 0, with the upper bytes zero. `req_size` 2 or 3 is a word access and ignores `req_addr[1:0]`.
- R10: The read-only registers return these values:
  - block-max (0x10) reads LUT_WORDS;
  - block-config (0x14) reads BLOCK_LOG2-5;
  - status (0x20) reads `irq_stat_i`;
  - fault address (0x2C) and fault info (0x30) read their inputs.
- R11: Interrupt set and clear:
  - writing 1 to bit 0 of the set register (0x34) pulses `irq_set_o` in the response cycle;
  - writing 1 to bit 0 of the clear register (0x24) pulses `irq_clr_o` in the response cycle;
  - both registers read 0, and so do unmapped offsets;
  - `irq_o` equals `irq_stat_i` AND the interrupt enable.
- R12: Every request cycle is followed by exactly one cycle with `rsp_valid`=1. `rsp_rdata` holds the read data there, and holds 0 for writes and idle cycles.
- R13: The twelve words from 0xFD0 to 0xFFC read byte k of parameter ID_BYTES (bits 8k+7:8k, k = (offset-0xFD0)/4) in their low byte, whatever the security attribute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the register window |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Write data, low-aligned for sub-word writes |
| req_secure | input | 1 | Request carries the secure attribute |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data of that response |
| irq_stat_i | input | 1 | Interrupt status held by the filter block |
| fault_addr_i | input | 32 | Captured fault address |
| fault_info_i | input | 32 | Captured fault attributes |
| lut_word_o | output | 32 | Currently selected lookup word |
| lut_index_o | output | IDX_W | Current index |
| lockdown_o | output | 1 | Lockdown state |
| sec_resp_o | output | 1 | Error-response mode for blocked accesses |
| irq_o | output | 1 | Interrupt request |
| irq_set_o | output | 1 | One-cycle strobe: set interrupt status |
| irq_clr_o | output | 1 | One-cycle strobe: clear interrupt status |

## Verification
The checker assumes the following about the inputs:
- requests appear only while reset is released;
- at most one request is presented per cycle;
- the filter block drives the fault and status inputs without reference to the request stream.

The bench keeps within this. It issues one request at a time and releases it before the next one. It uses only the size codes 0 to 2, with halfword offsets aligned to two bytes. It changes `irq_stat_i` only between requests. Index stepping is checked with a non-power-of-two number of lookup words, so both the modulo path and the wrap path are exercised.

// File: rtl/mpc_rf_pkg.sv
package mpc_rf_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_BMAX  = 12'h010;
  localparam logic [11:0] OFS_BCFG  = 12'h014;
  localparam logic [11:0] OFS_BIDX  = 12'h018;
  localparam logic [11:0] OFS_BLUT  = 12'h01C;
  localparam logic [11:0] OFS_ISTAT = 12'h020;
  localparam logic [11:0] OFS_ICLR  = 12'h024;
  localparam logic [11:0] OFS_IEN   = 12'h028;
  localparam logic [11:0] OFS_FADDR = 12'h02C;
  localparam logic [11:0] OFS_FINFO = 12'h030;
  localparam logic [11:0] OFS_ISET  = 12'h034;
  localparam logic [11:0] OFS_ID_LO = 12'hFD0;

  localparam int CTRL_SECRESP_BIT = 4;
  localparam int CTRL_AUTOINC_BIT = 8;
  localparam int CTRL_LOCK_BIT    = 31;
  localparam logic [31:0] CTRL_KEEP  = 32'h8000_0110;
  localparam logic [31:0] CTRL_RESET = 32'h0000_0100;

  // Byte-lane mask of an access; word accesses ignore the low address bits.
  function automatic logic [31:0] lane_mask(input logic [1:0] size, input logic [1:0] lo);
    logic [31:0] base;
    case (size)
      SZ_BYTE: base = 32'h0000_00FF;
      SZ_HALF: base = 32'h0000_FFFF;
      default: base = 32'hFFFF_FFFF;
    endcase
    if (size == SZ_BYTE || size == SZ_HALF) return base << {lo, 3'b000};
    return base;
  endfunction

endpackage

// File: rtl/mpc_rf_lanes.sv
module mpc_rf_lanes
  import mpc_rf_pkg::*;
(
  input  logic [1:0]  size_i,
  input  logic [1:0]  lo_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] merge_base_i,
  input  logic [31:0] rd_word_i,
  output logic [31:0] wr_value_o,
  output logic [31:0] rd_value_o,
  output logic        full_word_o
);
  logic [31:0] mask;
  logic [4:0]  sh;

  assign full_word_o = !(size_i == SZ_BYTE || size_i == SZ_HALF);
  assign sh          = full_word_o ? 5'd0 : {lo_i, 3'b000};
  assign mask        = lane_mask(size_i, lo_i);
  assign wr_value_o  = (merge_base_i & ~mask) | ((wdata_i << sh) & mask);
  assign rd_value_o  = (rd_word_i & mask) >> sh;
endmodule

// File: rtl/mpc_rf_lut.sv
module mpc_rf_lut #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned IW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we_i,
  input  logic [31:0]   idx_val_i,
  input  logic          word_we_i,
  input  logic [31:0]   word_val_i,
  input  logic          advance_i,
  output logic [IW-1:0] idx_o,
  output logic [31:0]   word_o
);
  logic [IW-1:0] idx_q;
  logic [31:0]   words [WORDS];

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : g_word
      logic [31:0] w_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                w_q <= '0;
        else if (word_we_i && idx_q == IW'(g))     w_q <= word_val_i;
      end
      assign words[g] = w_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx_q <= '0;
    else if (idx_we_i)  idx_q <= IW'(idx_val_i % WORDS);
    else if (advance_i) idx_q <= (idx_q == IW'(WORDS - 1)) ? '0 : idx_q + IW'(1);
  end

  always_comb begin
    word_o = '0;
    for (int k = 0; k < int'(WORDS); k++)
      if (idx_q == IW'(k)) word_o = words[k];
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/mpc_rf_ctrl.sv
module mpc_rf_ctrl
  import mpc_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we_i,
  input  logic        ien_we_i,
  input  logic [31:0] wr_val_i,
  output logic [31:0] ctrl_o,
  output logic        ien_o
);
  logic [31:0] ctrl_q;
  logic        ien_q;
  logic        frozen;

  assign frozen = ctrl_q[CTRL_LOCK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      ien_q  <= 1'b1;
    end else begin
      if (ctrl_we_i && !frozen) ctrl_q <= wr_val_i & CTRL_KEEP;
      if (ien_we_i && !frozen)  ien_q  <= wr_val_i[0];
    end
  end

  assign ctrl_o = ctrl_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/mpc_lut_regfile.sv
module mpc_lut_regfile
  import mpc_rf_pkg::*;
#(
  parameter int unsigned LUT_WORDS  = 4,
  parameter int unsigned BLOCK_LOG2 = 12,
  parameter logic [95:0] ID_BYTES   = 96'hB105F00D_003BC471_00000004,
  localparam int unsigned IDX_W     = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [11:0]      req_addr,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  input  logic             req_secure,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  input  logic             irq_stat_i,
  input  logic [31:0]      fault_addr_i,
  input  logic [31:0]      fault_info_i,
  output logic [31:0]      lut_word_o,
  output logic [IDX_W-1:0] lut_index_o,
  output logic             lockdown_o,
  output logic             sec_resp_o,
  output logic             irq_o,
  output logic             irq_set_o,
  output logic             irq_clr_o
);
  logic [11:0] ofs;
  logic        in_id, granted, wr_acc, rd_acc;
  logic [31:0] ctrl_q, cur_word, merge_base, rd_word, wr_value, rd_value;
  logic        ien_q, full_word, lock;
  logic [IDX_W-1:0] idx_q;
  logic [3:0]  id_sel;
  logic        lut_hit, lut_we, idx_we, ctrl_we, ien_we, advance, set_d, clr_d;
  logic        rsp_valid_q, set_q, clr_q;
  logic [31:0] rsp_rdata_q;

  assign ofs     = {req_addr[11:2], 2'b00};
  assign in_id   = req_addr >= OFS_ID_LO;
  assign granted = req_valid && (req_secure || in_id);
  assign wr_acc  = granted && req_write;
  assign rd_acc  = granted && !req_write;
  assign lock    = ctrl_q[CTRL_LOCK_BIT];
  assign id_sel  = 4'(ofs[11:2] - OFS_ID_LO[11:2]);

  always_comb begin
    case (ofs)
      OFS_CTRL: merge_base = ctrl_q;
      OFS_BIDX: merge_base = 32'(idx_q);
      OFS_BLUT: merge_base = cur_word;
      default:  merge_base = '0;
    endcase
  end

  always_comb begin
    case (ofs)
      OFS_CTRL:  rd_word = ctrl_q;
      OFS_BMAX:  rd_word = 32'(LUT_WORDS);
      OFS_BCFG:  rd_word = 32'(BLOCK_LOG2 - 5);
      OFS_BIDX:  rd_word = 32'(idx_q);
      OFS_BLUT:  rd_word = cur_word;
      OFS_ISTAT: rd_word = {31'd0, irq_stat_i};
      OFS_IEN:   rd_word = {31'd0, ien_q};
      OFS_FADDR: rd_word = fault_addr_i;
      OFS_FINFO: rd_word = fault_info_i;
      default:   rd_word = in_id ? {24'd0, ID_BYTES[id_sel*8 +: 8]} : 32'd0;
    endcase
  end

  mpc_rf_lanes u_lanes (
    .size_i       (req_size),
    .lo_i         (req_addr[1:0]),
    .wdata_i      (req_wdata),
    .merge_base_i (merge_base),
    .rd_word_i    (rd_word),
    .wr_value_o   (wr_value),
    .rd_value_o   (rd_value),
    .full_word_o  (full_word)
  );

  assign ctrl_we = wr_acc && ofs == OFS_CTRL;
  assign ien_we  = wr_acc && ofs == OFS_IEN;
  assign idx_we  = wr_acc && ofs == OFS_BIDX;
  assign lut_hit = granted && ofs == OFS_BLUT;
  assign lut_we  = lut_hit && req_write && !lock;
  assign advance = lut_hit && full_word && ctrl_q[CTRL_AUTOINC_BIT] && !(req_write && lock);
  assign set_d   = wr_acc && ofs == OFS_ISET && wr_value[0];
  assign clr_d   = wr_acc && ofs == OFS_ICLR && wr_value[0];

  mpc_rf_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we_i (ctrl_we),
    .ien_we_i  (ien_we),
    .wr_val_i  (wr_value),
    .ctrl_o    (ctrl_q),
    .ien_o     (ien_q)
  );

  mpc_rf_lut #(.WORDS(LUT_WORDS), .IW(IDX_W)) u_lut (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_we_i   (idx_we),
    .idx_val_i  (wr_value),
    .word_we_i  (lut_we),
    .word_val_i (wr_value),
    .advance_i  (advance),
    .idx_o      (idx_q),
    .word_o     (cur_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      set_q       <= 1'b0;
      clr_q       <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_rdata_q <= rd_acc ? rd_value : 32'd0;
      set_q       <= set_d;
      clr_q       <= clr_d;
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_rdata_q;
  assign lut_word_o  = cur_word;
  assign lut_index_o = idx_q;
  assign lockdown_o  = lock;
  assign sec_resp_o  = ctrl_q[CTRL_SECRESP_BIT];
  assign irq_o       = irq_stat_i && ien_q;
  assign irq_set_o   = set_q;
  assign irq_clr_o   = clr_q;
endmodule

// File: rtl/mpc_rf_checker.sv
module mpc_rf_checker #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned IW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          req_secure,
  input logic [11:0]   req_addr,
  input logic          rsp_valid,
  input logic [31:0]   rsp_rdata,
  input logic [IW-1:0] lut_index,
  input logic [31:0]   lut_word,
  input logic          lockdown,
  input logic          sec_resp,
  input logic          irq_set,
  input logic          irq_clr
);
  logic ns_low;
  assign ns_low = req_valid && !req_secure && req_addr < 12'hFD0;

  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_ns_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_low && !req_write) |=> rsp_rdata == 32'd0);
  assert_ns_no_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ns_low |=> ($stable(lut_index) && $stable(lut_word) && $stable(lockdown)
                && $stable(sec_resp) && !irq_set && !irq_clr));
  assert_index_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(lut_index) < WORDS);
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown |=> lockdown);
  assert_locked_lut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lockdown && req_valid && req_write && req_secure && req_addr[11:2] == 10'h007)
      |=> ($stable(lut_word) && $stable(lut_index)));
  assert_strobe_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set || irq_clr) |-> $past(req_valid && req_write && req_secure));
endmodule

bind mpc_lut_regfile mpc_rf_checker #(.WORDS(LUT_WORDS), .IW(IDX_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_secure (req_secure),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .lut_index  (lut_index_o),
  .lut_word   (lut_word_o),
  .lockdown   (lockdown_o),
  .sec_resp   (sec_resp_o),
  .irq_set    (irq_set_o),
  .irq_clr    (irq_clr_o)
);

// File: tb/test_mpc_lut_regfile.sv
module test_mpc_lut_regfile;
  localparam int unsigned NW   = 3;
  localparam int unsigned BLOG = 12;
  localparam int unsigned IW   = 2;
  localparam logic [95:0] IDB  = 96'hB105F00D_003BC471_00000004;
  localparam logic [31:0] FADDR = 32'h2000_4A40;
  localparam logic [31:0] FINFO = 32'h0003_0012;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, lockdown_o, sec_resp_o, irq_o, irq_set_o, irq_clr_o;
  logic [31:0] rsp_rdata, lut_word_o;
  logic [IW-1:0] lut_index_o;
  logic irq_stat_i = 1'b0;

  mpc_lut_regfile #(.LUT_WORDS(NW), .BLOCK_LOG2(BLOG), .ID_BYTES(IDB)) i_mpc_lut_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_secure(req_secure), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_stat_i(irq_stat_i), .fault_addr_i(FADDR), .fault_info_i(FINFO),
    .lut_word_o(lut_word_o), .lut_index_o(lut_index_o), .lockdown_o(lockdown_o),
    .sec_resp_o(sec_resp_o), .irq_o(irq_o), .irq_set_o(irq_set_o), .irq_clr_o(irq_clr_o)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model
  logic [31:0] m_ctrl;
  logic [31:0] m_lut [NW];
  int unsigned m_idx;
  bit m_ien;
  bit e_rv, e_set, e_clr;
  logic [31:0] e_rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_ctrl = 32'h100; m_idx = 0; m_ien = 1'b1;
    for (int i = 0; i < int'(NW); i++) m_lut[i] = '0;
    e_rv = 0; e_rd = '0; e_set = 0; e_clr = 0;
  endfunction

  function automatic int nbytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] m_word(input logic [11:0] o);
    if (o >= 12'hFD0) return {24'd0, IDB[((o - 12'hFD0) >> 2) * 8 +: 8]};
    case (o)
      12'h000: return m_ctrl;
      12'h010: return NW;
      12'h014: return BLOG - 5;
      12'h018: return m_idx;
      12'h01C: return m_lut[m_idx];
      12'h020: return {31'd0, irq_stat_i};
      12'h028: return {31'd0, m_ien};
      12'h02C: return FADDR;
      12'h030: return FINFO;
      default: return 32'd0;
    endcase
  endfunction

  task automatic tick(input string tag);
    @(negedge clk);
    chk({tag, " rsp_valid R12"}, {31'd0, rsp_valid}, {31'd0, e_rv});
    chk({tag, " rsp_rdata R12"}, rsp_rdata, e_rd);
    chk({tag, " irq_set_o R11"}, {31'd0, irq_set_o}, {31'd0, e_set});
    chk({tag, " irq_clr_o R11"}, {31'd0, irq_clr_o}, {31'd0, e_clr});
    chk({tag, " lut_word_o R4"}, lut_word_o, m_lut[m_idx]);
    chk({tag, " lut_index_o R5"}, 32'(lut_index_o), m_idx);
    chk({tag, " lockdown_o R7"}, {31'd0, lockdown_o}, {31'd0, m_ctrl[31]});
    chk({tag, " sec_resp_o R2"}, {31'd0, sec_resp_o}, {31'd0, m_ctrl[4]});
    chk({tag, " irq_o R11"}, {31'd0, irq_o}, {31'd0, irq_stat_i & m_ien});
    req_valid = 0;
    e_rv = 0; e_rd = '0; e_set = 0; e_clr = 0;
  endtask

  task automatic acc(input bit wr, input logic [11:0] a, input int sz,
                     input logic [31:0] wd, input bit sec, input string tag);
    logic [11:0] o;
    int lo, n;
    bit full, lock;
    logic [31:0] base, v, w;
    o = a & 12'hFFC; full = (sz >= 2); lo = full ? 0 : int'(a[1:0]); n = nbytes(sz);
    lock = m_ctrl[31];
    req_valid = 1; req_write = wr; req_addr = a; req_size = 2'(sz);
    req_wdata = wd; req_secure = sec;
    e_rv = 1; e_rd = '0; e_set = 0; e_clr = 0;
    if (sec || a >= 12'hFD0) begin
      if (!wr) begin
        w = m_word(o);
        for (int j = 0; j < n; j++) if (lo + j < 4) e_rd[8*j +: 8] = w[8*(lo+j) +: 8];
        if (o == 12'h01C && full && m_ctrl[8]) m_idx = (m_idx + 1) % NW;
      end else begin
        base = (o == 12'h000) ? m_ctrl : (o == 12'h018) ? m_idx :
               (o == 12'h01C) ? m_lut[m_idx] : 32'd0;
        v = base;
        for (int j = 0; j < n; j++) if (lo + j < 4) v[8*(lo+j) +: 8] = wd[8*j +: 8];
        case (o)
          12'h000: if (!lock) m_ctrl = v & 32'h8000_0110;
          12'h018: m_idx = v % NW;
          12'h01C: if (!lock) begin
                     m_lut[m_idx] = v;
                     if (full && m_ctrl[8]) m_idx = (m_idx + 1) % NW;
                   end
          12'h028: if (!lock) m_ien = v[0];
          12'h024: e_clr = v[0];
          12'h034: e_set = v[0];
          default: ;
        endcase
      end
    end
    tick(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    tick("R1 after reset");
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R1 / R10 reset and constant values
    acc(0, 12'h000, 2, 0, 1, "R1 ctrl");
    acc(0, 12'h018, 2, 0, 1, "R1 index");
    acc(0, 12'h028, 2, 0, 1, "R1 enable");
    acc(0, 12'h01C, 2, 0, 1, "R1 lut zero");
    acc(0, 12'h010, 2, 0, 1, "R10 bmax");
    acc(0, 12'h014, 2, 0, 1, "R10 bcfg");
    // R2 control bits
    acc(1, 12'h000, 2, 32'h7FFF_FFFF, 1, "R2 ctrl write");
    acc(0, 12'h000, 2, 0, 1, "R2 ctrl read");
    // R3 non-secure, R13 id region
    acc(0, 12'h000, 2, 0, 0, "R3 ns read");
    acc(1, 12'h000, 2, 0, 0, "R3 ns ctrl write");
    acc(1, 12'h01C, 2, 32'hFFFF_FFFF, 0, "R3 ns lut write");
    acc(1, 12'h034, 2, 1, 0, "R3 ns set write");
    acc(0, 12'hFD0, 2, 0, 0, "R13 id first");
    acc(0, 12'hFFC, 2, 0, 0, "R13 id last");
    acc(0, 12'hFE4, 2, 0, 1, "R13 id mid");
    // R6 index modulo
    acc(1, 12'h018, 2, 7, 1, "R6 index 7");
    acc(0, 12'h018, 2, 0, 1, "R6 index read");
    acc(1, 12'h018, 2, 3, 1, "R6 index 3");
    // R4 / R5 lut with auto-increment and wrap
    acc(1, 12'h01C, 2, 32'hAAAA_5555, 1, "R4 lut w0");
    acc(1, 12'h01C, 2, 32'h1234_5678, 1, "R4 lut w1");
    acc(1, 12'h01C, 2, 32'hDEAD_BEEF, 1, "R5 lut w2 wrap");
    acc(0, 12'h01C, 2, 0, 1, "R5 lut r0");
    acc(0, 12'h01C, 2, 0, 1, "R5 lut r1");
    acc(0, 12'h01C, 2, 0, 1, "R5 lut r2");
    // R9 sub-word reads
    acc(0, 12'h01D, 0, 0, 1, "R9 lut byte1");
    acc(0, 12'h01E, 1, 0, 1, "R9 lut half hi");
    acc(0, 12'h001, 0, 0, 1, "R9 ctrl byte1");
    acc(0, 12'hFEA, 1, 0, 1, "R9 id half");
    // R8 sub-word writes
    acc(1, 12'h01D, 0, 32'h0000_00C3, 1, "R8 lut byte merge");
    acc(1, 12'h01C, 1, 32'h0000_7E7E, 1, "R8 lut half merge");
    acc(0, 12'h01C, 0, 0, 1, "R8 lut byte read");
    acc(1, 12'h000, 1, 32'h0000_0010, 1, "R8 ctrl half");
    acc(0, 12'h000, 2, 0, 1, "R8 ctrl read");
    acc(1, 12'h019, 0, 32'h0000_0001, 1, "R8 index byte");
    acc(0, 12'h018, 2, 0, 1, "R8 index read");
    acc(1, 12'h029, 0, 32'h0000_0001, 1, "R8 enable byte zero merge");
    acc(0, 12'h028, 2, 0, 1, "R8 enable read");
    acc(1, 12'h028, 2, 1, 1, "R8 enable word");
    // R5 no advance with auto-increment clear
    acc(1, 12'h01C, 2, 32'h0F0F_0F0F, 1, "R5 no autoinc");
    // R10 / R11 interrupt
    irq_stat_i = 1;
    acc(0, 12'h020, 2, 0, 1, "R10 status");
    acc(1, 12'h034, 2, 1, 1, "R11 set");
    acc(1, 12'h024, 2, 1, 1, "R11 clear");
    acc(1, 12'h035, 0, 1, 1, "R11 set byte lane1");
    acc(1, 12'h024, 2, 2, 1, "R11 clear bit1");
    acc(0, 12'h024, 2, 0, 1, "R11 clear reads zero");
    acc(0, 12'h034, 2, 0, 1, "R11 set reads zero");
    acc(0, 12'h00C, 2, 0, 1, "R11 unmapped");
    acc(1, 12'h028, 2, 0, 1, "R11 enable off");
    acc(1, 12'h028, 2, 1, 1, "R11 enable on");
    irq_stat_i = 0;
    acc(0, 12'h02C, 2, 0, 1, "R10 fault addr");
    acc(0, 12'h030, 2, 0, 1, "R10 fault info");
    // R7 lockdown
    acc(1, 12'h000, 2, 32'h8000_0100, 1, "R7 lock set");
    acc(1, 12'h000, 2, 32'h0000_0010, 1, "R7 ctrl frozen");
    acc(1, 12'h01C, 2, 32'h5A5A_5A5A, 1, "R7 lut frozen");
    acc(0, 12'h01C, 2, 0, 1, "R7 read advances");
    acc(1, 12'h028, 2, 0, 1, "R7 enable frozen");
    acc(0, 12'h028, 2, 0, 1, "R7 enable read");
    acc(1, 12'h018, 2, 5, 1, "R7 index still writable");
    acc(0, 12'h000, 2, 0, 1, "R7 ctrl read");
    do_reset();
    acc(0, 12'h000, 2, 0, 1, "R7 lock cleared");
    acc(0, 12'h01C, 2, 0, 1, "R1 lut cleared");
    tick("R12 idle");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule